// File: doc/BRIEF.md
# Period Timer with Prescale and Postscale

This block is an 8-bit up-counter that runs from a clock-enable tick. The tick first passes through a selectable input divider. The count is compared against a writable period value. When the two are equal at a divided tick, the count returns to zero, a one-cycle match pulse is produced, and that pulse can serve as the shift clock of a serial peripheral.

Match pulses also feed a programmable postscaler. On every (N+1)th match it raises a sticky interrupt flag. That flag stays high until an explicit clear input is pulsed.

Software reaches the block through three write strobes that share one data bus: count, period and control. A select input picks the register that is returned on the read bus. Writes to the count or control register restart both the divider and the postscaler. A control write leaves the count untouched.

Top module: `period_timer`

## Requirements
- R1: After reset the count reads 0x00, the period reads 0xFF, the control register reads 0x00, and both `match_o` and `irq_o` are low.
- R2: While enabled, each divided tick adds one to the count if the count differs from the period. If the count equals the period at a divided tick, the count is 0x00 on the next cycle and `match_o` is high for that cycle only.
- R3: Control bits [1:0] pick the input divider: 00 passes every tick, 01 takes every 4th tick and 1x takes every 16th tick of `tick_i`. A cycle with `tick_i` low does not advance the divider.
- R4: Control bits [6:3] hold N. `irq_o` is set on every (N+1)th match pulse, in the same cycle as that pulse.
- R5: With control bit 2 at 0, the count, divider and postscaler hold their values and no match occurs.
- R6: A count write loads the bus value and clears the divider and postscaler.
- R7: A control write stores bits [6:3], 2 and [1:0], clears the divider and postscaler, and leaves the count unchanged.
- R8: In any cycle that carries a write strobe, the timer does not step: there is no increment and no match from that cycle.
- R9: `irq_o` stays high until `irq_clr_i` is pulsed. If a set and a clear fall in the same cycle, the flag ends up set.
- R10: `rd_sel_i` 00 returns the count, 01 the period, 10 the control register with bit 7 read as 0, and 11 returns zero. The read is combinational.
- R11: A count above the period keeps counting up, rolls from 0xFF to 0x00 without a match, and matches when it next equals the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable tick, before the divider |
| wr_data_i | input | 8 | Write data shared by all registers |
| cnt_we_i | input | 1 | Write strobe for the count register |
| per_we_i | input | 1 | Write strobe for the period register |
| ctl_we_i | input | 1 | Write strobe for the control register |
| rd_sel_i | input | 2 | Read register select |
| rd_data_o | output | 8 | Read data for the selected register |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| match_o | output | 1 | One-cycle pulse on each period match (shift clock) |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 4-bit divider and a 4-bit postscaler. With these settings all three divider ratios and every postscale ratio up to 1:16 can be reached in a few hundred cycles. Writing small periods keeps matches frequent, so the bench sees postscaler wraps, interrupt set/clear collisions and writes that land on a divided tick. Loading a count above the period exercises the roll past 0xFF in under 300 cycles.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   // Read select encoding.
   typedef enum logic [1:0] {
      RSEL_COUNT  = 2'd0,
      RSEL_PERIOD = 2'd1,
      RSEL_CTRL   = 2'd2,
      RSEL_NONE   = 2'd3
   } rsel_e;

   // Control register field positions.
   localparam int unsigned CTL_PRE_LSB  = 0;
   localparam int unsigned CTL_PRE_W    = 2;
   localparam int unsigned CTL_EN_BIT   = 2;
   localparam int unsigned CTL_POST_LSB = 3;

   // Number of selectable divider ratios.
   localparam int unsigned NUM_RATIO = 3;

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
   parameter int unsigned PRE_W = 4
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              clr_i,
   input  logic                              adv_i,
   input  logic [ptmr_pkg::CTL_PRE_W-1:0]    sel_i,
   output logic                              step_o
);
   import ptmr_pkg::*;

   localparam int unsigned MID_SHIFT = PRE_W / 2;

   if (PRE_W < 2) begin : g_bad_width
      $error("ptmr_prescaler: PRE_W must be at least 2");
   end

   // Terminal count for each ratio: 1, 2^(PRE_W/2), 2^PRE_W.
   logic [PRE_W-1:0] term [NUM_RATIO];

   for (genvar k = 0; k < NUM_RATIO; k++) begin : g_term
      localparam int unsigned SHIFT = (k == 0) ? 0 :
                                      (k == 1) ? MID_SHIFT : PRE_W;
      assign term[k] = PRE_W'((64'd1 << SHIFT) - 64'd1);
   end

   logic [PRE_W-1:0] term_sel;
   logic [PRE_W-1:0] pre_q;

   always_comb begin
      case (sel_i)
         2'b00:   term_sel = term[0];
         2'b01:   term_sel = term[1];
         default: term_sel = term[2];
      endcase
   end

   assign step_o = adv_i && (pre_q == term_sel);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q <= '0;
      end else if (clr_i) begin
         pre_q <= '0;
      end else if (adv_i) begin
         if (step_o) begin
            pre_q <= '0;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             per_we_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             step_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] per_o,
   output logic             evt_o,
   output logic             match_o
);

   if (CNT_W < 2) begin : g_bad_width
      $error("ptmr_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic             match_q;
   logic             equal;

   assign equal = (cnt_q == per_q);
   assign evt_o = step_i && equal;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= wr_data_i;
      end else if (step_i) begin
         if (equal) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         per_q <= '1;
      end else if (per_we_i) begin
         per_q <= wr_data_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         match_q <= 1'b0;
      end else begin
         match_q <= evt_o;
      end
   end

   assign cnt_o   = cnt_q;
   assign per_o   = per_q;
   assign match_o = match_q;

endmodule

// File: rtl/ptmr_postscaler.sv
module ptmr_postscaler #(
   parameter int unsigned POST_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              evt_i,
   input  logic [POST_W-1:0] sel_i,
   input  logic              irq_clr_i,
   output logic              irq_o
);

   if (POST_W < 1) begin : g_bad_width
      $error("ptmr_postscaler: POST_W must be at least 1");
   end

   logic [POST_W-1:0] post_q;
   logic              irq_q;
   logic              fire;

   assign fire = evt_i && (post_q == sel_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         post_q <= '0;
      end else if (clr_i) begin
         post_q <= '0;
      end else if (evt_i) begin
         if (fire) begin
            post_q <= '0;
         end else begin
            post_q <= post_q + 1'b1;
         end
      end
   end

   // A set in the same cycle as a clear wins.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_q <= 1'b0;
      end else if (fire) begin
         irq_q <= 1'b1;
      end else if (irq_clr_i) begin
         irq_q <= 1'b0;
      end
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/period_timer.sv
module period_timer #(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned PRE_W  = 4,
   parameter int unsigned POST_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             cnt_we_i,
   input  logic             per_we_i,
   input  logic             ctl_we_i,
   input  logic [1:0]       rd_sel_i,
   output logic [CNT_W-1:0] rd_data_o,
   input  logic             irq_clr_i,
   output logic             match_o,
   output logic             irq_o
);
   import ptmr_pkg::*;

   localparam int unsigned CTL_TOP = CTL_POST_LSB + POST_W;

   // The control layout needs one unused bit above the postscale field.
   if (CTL_TOP >= CNT_W) begin : g_bad_layout
      $error("period_timer: control fields do not fit in CNT_W");
   end

   logic                 ctl_en_q;
   logic [CTL_PRE_W-1:0] ctl_pre_q;
   logic [POST_W-1:0]    ctl_post_q;

   logic             any_wr;
   logic             adv;
   logic             seq_clr;
   logic             step;
   logic             evt;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] per_w;

   assign any_wr  = cnt_we_i || per_we_i || ctl_we_i;
   assign adv     = tick_i && ctl_en_q && !any_wr;
   assign seq_clr = cnt_we_i || ctl_we_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl_en_q   <= 1'b0;
         ctl_pre_q  <= '0;
         ctl_post_q <= '0;
      end else if (ctl_we_i) begin
         ctl_en_q   <= wr_data_i[CTL_EN_BIT];
         ctl_pre_q  <= wr_data_i[CTL_PRE_LSB +: CTL_PRE_W];
         ctl_post_q <= wr_data_i[CTL_POST_LSB +: POST_W];
      end
   end

   ptmr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (seq_clr),
      .adv_i  (adv),
      .sel_i  (ctl_pre_q),
      .step_o (step)
   );

   ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (cnt_we_i),
      .per_we_i  (per_we_i),
      .wr_data_i (wr_data_i),
      .step_i    (step),
      .cnt_o     (cnt_w),
      .per_o     (per_w),
      .evt_o     (evt),
      .match_o   (match_o)
   );

   ptmr_postscaler #(.POST_W(POST_W)) u_post (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (seq_clr),
      .evt_i     (evt),
      .sel_i     (ctl_post_q),
      .irq_clr_i (irq_clr_i),
      .irq_o     (irq_o)
   );

   always_comb begin
      rd_data_o = '0;
      case (rsel_e'(rd_sel_i))
         RSEL_COUNT:  rd_data_o = cnt_w;
         RSEL_PERIOD: rd_data_o = per_w;
         RSEL_CTRL: begin
            rd_data_o[CTL_PRE_LSB +: CTL_PRE_W] = ctl_pre_q;
            rd_data_o[CTL_EN_BIT]               = ctl_en_q;
            rd_data_o[CTL_POST_LSB +: POST_W]   = ctl_post_q;
         end
         default:     rd_data_o = '0;
      endcase
   end

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             cnt_we_i,
   input logic             per_we_i,
   input logic             ctl_we_i,
   input logic [CNT_W-1:0] wr_data_i,
   input logic             en_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic [CNT_W-1:0] per_i,
   input logic             match_i,
   input logic             irq_i,
   input logic             irq_clr_i,
   input logic [1:0]       rd_sel_i,
   input logic [CNT_W-1:0] rd_data_i
);

   logic any_wr;
   assign any_wr = cnt_we_i || per_we_i || ctl_we_i;

   p_match_from_equal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_i |-> $past(cnt_i == per_i));

   p_match_zeroes_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_i |-> (cnt_i == '0));

   p_hold_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !any_wr) |=> $stable(cnt_i));

   p_count_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_we_i |=> (cnt_i == $past(wr_data_i)));

   p_ctl_keeps_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_we_i && !cnt_we_i) |=> $stable(cnt_i));

   p_write_blocks_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_wr |=> !match_i);

   p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_i && !irq_clr_i) |=> irq_i);

   p_ctrl_top_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_sel_i == 2'd2) |-> (rd_data_i[CNT_W-1] == 1'b0));

endmodule

bind period_timer ptmr_checker #(.CNT_W(CNT_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .cnt_we_i  (cnt_we_i),
   .per_we_i  (per_we_i),
   .ctl_we_i  (ctl_we_i),
   .wr_data_i (wr_data_i),
   .en_i      (ctl_en_q),
   .cnt_i     (cnt_w),
   .per_i     (per_w),
   .match_i   (match_o),
   .irq_i     (irq_o),
   .irq_clr_i (irq_clr_i),
   .rd_sel_i  (rd_sel_i),
   .rd_data_i (rd_data_o)
);

// File: tb/period_timer_tb_top.sv
module period_timer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       cnt_we = 1'b0;
   logic       per_we = 1'b0;
   logic       ctl_we = 1'b0;
   logic [1:0] rd_sel = 2'd0;
   logic [7:0] rd_data;
   logic       irq_clr = 1'b0;
   logic       match;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   string cur_tag = "R1";

   // Reference model state.
   int m_cnt, m_per, m_en, m_psel, m_post_sel, m_pre, m_post, m_match, m_irq;

   always #5 clk = ~clk;

   period_timer dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .tick_i    (tick),
      .wr_data_i (wdata),
      .cnt_we_i  (cnt_we),
      .per_we_i  (per_we),
      .ctl_we_i  (ctl_we),
      .rd_sel_i  (rd_sel),
      .rd_data_o (rd_data),
      .irq_clr_i (irq_clr),
      .match_o   (match),
      .irq_o     (irq)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   function automatic int exp_rd(input int sel);
      case (sel)
         0: return m_cnt;
         1: return m_per;
         2: return (m_post_sel << 3) | (m_en << 2) | m_psel;
         default: return 0;
      endcase
   endfunction

   // Cycle model and per-cycle comparison.
   always @(posedge clk) begin
      int any_wr, div, set_irq, nm;
      if (!rst_n) begin
         m_cnt = 0; m_per = 255; m_en = 0; m_psel = 0; m_post_sel = 0;
         m_pre = 0; m_post = 0; m_match = 0; m_irq = 0;
      end else begin
         any_wr = int'(cnt_we | per_we | ctl_we);
         nm = 0;
         set_irq = 0;
         if (any_wr != 0) begin
            if (cnt_we) m_cnt = int'(wdata);
            if (per_we) m_per = int'(wdata);
            if (ctl_we) begin
               m_psel     = int'(wdata[1:0]);
               m_en       = int'(wdata[2]);
               m_post_sel = int'(wdata[6:3]);
            end
            if (cnt_we || ctl_we) begin
               m_pre = 0;
               m_post = 0;
            end
         end else if (m_en != 0 && tick) begin
            div = (m_psel == 0) ? 1 : (m_psel == 1) ? 4 : 16;
            if (m_pre == div - 1) begin
               m_pre = 0;
               if (m_cnt == m_per) begin
                  m_cnt = 0;
                  nm = 1;
                  if (m_post == m_post_sel) begin
                     m_post = 0;
                     set_irq = 1;
                  end else begin
                     m_post++;
                  end
               end else begin
                  m_cnt = (m_cnt + 1) % 256;
               end
            end else begin
               m_pre++;
            end
         end
         m_match = nm;
         if (set_irq != 0) m_irq = 1;
         else if (irq_clr) m_irq = 0;
      end
      #3;
      if (rst_n) begin
         chk(cur_tag, "rd_data", int'(rd_data), exp_rd(int'(rd_sel)));
         chk(cur_tag, "match_o", int'(match), m_match);
         chk(cur_tag, "irq_o", int'(irq), m_irq);
      end
   end

   // Watchdog.
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
         report();
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // which: 0 count, 1 period, 2 control
   task automatic wr(input int which, input int val);
      @(negedge clk);
      wdata  = 8'(val);
      cnt_we = (which == 0);
      per_we = (which == 1);
      ctl_we = (which == 2);
      @(negedge clk);
      cnt_we = 1'b0;
      per_we = 1'b0;
      ctl_we = 1'b0;
   endtask

   initial begin
      // R1 reset state, R10 read select during reset
      idle(2);
      rd_sel = 2'd0; #1 chk("R1", "count at reset", int'(rd_data), 0);
      rd_sel = 2'd1; #1 chk("R1", "period at reset", int'(rd_data), 255);
      rd_sel = 2'd2; #1 chk("R1", "control at reset", int'(rd_data), 0);
      rd_sel = 2'd3; #1 chk("R10", "unused select", int'(rd_data), 0);
      chk("R1", "match at reset", int'(match), 0);
      chk("R1", "irq at reset", int'(irq), 0);
      @(negedge clk);
      rd_sel = 2'd0;
      rst_n = 1'b1;
      idle(2);

      // R2 basic counting and match, ratio 1, postscale 1:1
      cur_tag = "R2";
      wr(1, 5);
      tick = 1'b1;
      wr(2, 8'h04);
      idle(40);

      // R3 divider ratios with irregular ticks
      cur_tag = "R3";
      wr(2, 8'h05);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         tick = ($urandom_range(0, 9) < 7);
      end
      wr(2, 8'h06);
      tick = 1'b1;
      idle(250);
      wr(2, 8'h07);
      idle(250);

      // R4 postscale 1:4 with period 2
      cur_tag = "R4";
      wr(1, 2);
      wr(2, 8'h1C);
      idle(100);
      wr(2, 8'h7C);
      idle(120);

      // R9 interrupt clear pulses, including collisions with a set
      cur_tag = "R9";
      wr(2, 8'h0C);
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         irq_clr = ($urandom_range(0, 3) == 0);
      end
      irq_clr = 1'b0;

      // R5 disable holds state
      cur_tag = "R5";
      wr(1, 9);
      wr(2, 8'h1D);
      idle(37);
      wr(2, 8'h19);
      idle(60);
      wr(2, 8'h1D);
      idle(60);

      // R6 count writes in the middle of a run
      cur_tag = "R6";
      wr(1, 8'h20);
      wr(2, 8'h0D);
      for (int i = 0; i < 10; i++) begin
         idle($urandom_range(3, 12));
         wr(0, $urandom_range(0, 32));
      end
      idle(40);

      // R7 control writes in the middle of a run
      cur_tag = "R7";
      for (int i = 0; i < 10; i++) begin
         idle($urandom_range(3, 15));
         wr(2, 8'h0D | ($urandom_range(0, 1) << 1));
      end
      idle(40);

      // R11 count above period rolls over
      cur_tag = "R11";
      wr(1, 8'h10);
      wr(2, 8'h04);
      wr(0, 8'hF0);
      idle(80);

      // R8 and R10: random writes, ticks, clears and read selects
      cur_tag = "R8";
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         tick    = ($urandom_range(0, 9) < 8);
         irq_clr = ($urandom_range(0, 15) == 0);
         rd_sel  = 2'($urandom_range(0, 3));
         case ($urandom_range(0, 39))
            0: begin wdata = 8'($urandom_range(0, 20)); cnt_we = 1'b1; end
            1: begin wdata = 8'($urandom_range(0, 12)); per_we = 1'b1; end
            2: begin wdata = 8'($urandom_range(0, 255) | 4); ctl_we = 1'b1; end
            3: begin wdata = 8'($urandom_range(0, 255)); ctl_we = 1'b1; end
            default: begin end
         endcase
         @(negedge clk);
         cnt_we = 1'b0;
         per_we = 1'b0;
         ctl_we = 1'b0;
      end
      cur_tag = "R10";
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         rd_sel = 2'(i % 4);
      end
      idle(3);
      report();
   end

endmodule